// File: doc/BRIEF.md
# Reference Clock Loss Detector

This block watches a slow reference clock while a fast, multiplied clock runs the system logic, and reports whether the reference has stopped. The reference comes in as an ordinary digital input. It passes through a two-flop synchronizer into the fast domain, and a rising-edge detector follows the synchronizer. A small register interface holds three things: a select bit that marks the multiplied clock as the system clock, a status/arm bit for loss detection, and an 8-bit programming register whose upper nibble is the frequency multiplier N.

Software starts a check by writing 1 to the arm bit with the select bit set. The block then counts a window of 4×N fast-clock cycles. If no synchronized rising edge of the reference appears within that window, the status becomes 1, meaning the reference is lost. If an edge does appear, the status becomes 0. The status reads 0 whenever the select bit is clear.

Top module: `refclk_loss_det`

## Requirements
- R1: Address 0 is the control register. Bit 0 is the loss status and arm bit, bit 1 is the select bit, and all other bits read 0. Address 1 is the programming register: bits 7:4 hold the multiplier and bits 3:0 are spare storage. After reset the control register reads 0x00 and the programming register reads 0x66. `rd_data` is registered and shows the register that `addr` selected at the previous clock edge.
- R2: A write to address 0 with bits 0 and 1 both set starts a check. The check window lasts 4×N clock cycles, counted from the clock edge that captures the write.
- R3: N equals the multiplier field, except that a field value of 0 gives the same window as a value of 1 (4 cycles).
- R4: The status is updated on the last clock edge of the window. It becomes 1 if no synchronized rising edge of the reference was seen during the window, and 0 otherwise. The new value appears on `rd_data` one cycle later.
- R5: The reference passes through a two-flop synchronizer, and only its rising edges count as activity.
- R6: While the select bit is clear, the status reads 0 and no check runs. An arm write that also clears the select bit starts nothing. Clearing the select bit during a check aborts it and clears the status.
- R7: An arm write during a check restarts the window from zero and discards any edges already seen.
- R8: Writing 0 to bit 0 of the control register, with bit 1 set, does not disturb a check in progress.
- R9: Bits 3:0 of the programming register read back as written and have no effect on the window length.
- R10: The status keeps its previous value while a check is running, until the window ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Multiplied (fast) system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 = control, 1 = programming |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: a 4-bit multiplier field, a window scale of 4 and a two-stage synchronizer. With these values the whole multiplier range fits in the run, from the shortest 4-cycle window (field 0 or 1) to the longest 60-cycle window (field 15). The 4-cycle window is short enough that edge-to-readback timing, re-arm restart and the held old status can be checked on exact cycles. The longer windows are run with reference periods that fit inside them, so both outcomes are reached at several values of N.

// File: rtl/refwatch_pkg.sv
`timescale 1ns/1ps
package refwatch_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned PROG_ADDR = 1;
  localparam int unsigned ARM_BIT   = 0;
  localparam int unsigned SEL_BIT   = 1;
endpackage

// File: rtl/refwatch_sync.sv
`timescale 1ns/1ps
module refwatch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/refwatch_timer.sv
`timescale 1ns/1ps
module refwatch_timer #(
  parameter int MUL_W     = 4,
  parameter int WIN_SCALE = 4,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             sel_i,
  input  logic [MUL_W-1:0] mul_i,
  input  logic             rise_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             status_o
);
  logic [MUL_W-1:0] n_eff;
  logic [CNT_W-1:0] last_cnt;
  logic             seen_q;

  always_comb begin
    n_eff    = (mul_i == '0) ? MUL_W'(1) : mul_i;
    last_cnt = CNT_W'(CNT_W'(n_eff) * CNT_W'(WIN_SCALE) - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      cnt_o    <= '0;
      seen_q   <= 1'b0;
      status_o <= 1'b0;
    end else if (arm_i) begin
      busy_o <= 1'b1;
      cnt_o  <= '0;
      seen_q <= 1'b0;
    end else if (!sel_i) begin
      busy_o   <= 1'b0;
      cnt_o    <= '0;
      seen_q   <= 1'b0;
      status_o <= 1'b0;
    end else if (busy_o) begin
      if (cnt_o == last_cnt) begin
        busy_o   <= 1'b0;
        cnt_o    <= '0;
        seen_q   <= 1'b0;
        status_o <= ~(seen_q | rise_i);
      end else begin
        cnt_o  <= cnt_o + CNT_W'(1);
        seen_q <= seen_q | rise_i;
      end
    end
  end
endmodule

// File: rtl/refwatch_regs.sv
`timescale 1ns/1ps
module refwatch_regs
  import refwatch_pkg::*;
#(
  parameter int                  DATA_W   = 8,
  parameter int                  MUL_W    = 4,
  parameter logic [DATA_W-1:0]   PROG_RST = 8'h66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              status_i,
  output logic              arm_o,
  output logic              sel_o,
  output logic [MUL_W-1:0]  mul_o,
  output logic [DATA_W-1:0] prog_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              ctrl_wr;
  logic              prog_wr;
  logic [DATA_W-1:0] ctrl_view;

  always_comb begin
    ctrl_wr = wr_en_i && (addr_i == 1'(CTRL_ADDR));
    prog_wr = wr_en_i && (addr_i == 1'(PROG_ADDR));
    arm_o   = ctrl_wr && wr_data_i[ARM_BIT] && wr_data_i[SEL_BIT];
    mul_o   = prog_o[DATA_W-1 -: MUL_W];
    ctrl_view          = '0;
    ctrl_view[SEL_BIT] = sel_o;
    ctrl_view[ARM_BIT] = status_i & sel_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= 1'b0;
      prog_o <= PROG_RST;
    end else begin
      if (ctrl_wr) sel_o  <= wr_data_i[SEL_BIT];
      if (prog_wr) prog_o <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              rd_data_o <= '0;
    else if (addr_i == 1'(CTRL_ADDR))     rd_data_o <= ctrl_view;
    else                                  rd_data_o <= prog_o;
  end
endmodule

// File: rtl/refclk_loss_det.sv
`timescale 1ns/1ps
module refclk_loss_det #(
  parameter int         DATA_W      = 8,
  parameter int         MUL_W       = 4,
  parameter int         WIN_SCALE   = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] PROG_RST    = 8'h66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int MAX_LEN = ((1 << MUL_W) - 1) * WIN_SCALE;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic              rise_w;
  logic              arm_w;
  logic              sel_w;
  logic [MUL_W-1:0]  mul_w;
  logic [DATA_W-1:0] prog_w;
  logic              busy_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              status_w;

  refwatch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ref_clk_i),
    .rise_o  (rise_w)
  );

  refwatch_regs #(
    .DATA_W   (DATA_W),
    .MUL_W    (MUL_W),
    .PROG_RST (DATA_W'(PROG_RST))
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .status_i  (status_w),
    .arm_o     (arm_w),
    .sel_o     (sel_w),
    .mul_o     (mul_w),
    .prog_o    (prog_w),
    .rd_data_o (rd_data_o)
  );

  refwatch_timer #(
    .MUL_W     (MUL_W),
    .WIN_SCALE (WIN_SCALE),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (arm_w),
    .sel_i    (sel_w),
    .mul_i    (mul_w),
    .rise_i   (rise_w),
    .busy_o   (busy_w),
    .cnt_o    (cnt_w),
    .status_o (status_w)
  );
endmodule

// File: rtl/refclk_loss_det_chk.sv
`timescale 1ns/1ps
module refclk_loss_det_chk #(
  parameter int         DATA_W    = 8,
  parameter int         MUL_W     = 4,
  parameter int         WIN_SCALE = 4,
  parameter int         CNT_W     = 6,
  parameter logic [7:0] PROG_RST  = 8'h66
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic              addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              sel_w,
  input logic              busy_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [DATA_W-1:0] prog_w
);
  logic [MUL_W-1:0] chk_n;
  logic [CNT_W:0]   chk_len;
  logic             ctrl_write;

  always_comb begin
    chk_n      = (prog_w[DATA_W-1 -: MUL_W] == '0) ? MUL_W'(1) : prog_w[DATA_W-1 -: MUL_W];
    chk_len    = (CNT_W+1)'(chk_n) * (CNT_W+1)'(WIN_SCALE);
    ctrl_write = wr_en_i && (addr_i == 1'b0);
  end

  a_r1_prog_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> prog_w == DATA_W'(PROG_RST));

  a_r2_arm_starts: assert property (@(posedge clk) disable iff (rst)
    (ctrl_write && wr_data_i[0] && wr_data_i[1]) |=> (busy_w && cnt_w == '0));

  a_r3_window_bound: assert property (@(posedge clk) disable iff (rst)
    busy_w |-> ((CNT_W+1)'(cnt_w) < chk_len));

  a_r6_masked_read: assert property (@(posedge clk) disable iff (rst)
    (addr_i == 1'b0 && !sel_w) |=> (rd_data_o[0] == 1'b0));

  a_r6_idle_deselected: assert property (@(posedge clk) disable iff (rst)
    (!sel_w && !(ctrl_write && wr_data_i[0] && wr_data_i[1])) |=> !busy_w);

  a_r8_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (busy_w && sel_w && ctrl_write && !wr_data_i[0] && wr_data_i[1]
     && ((CNT_W+1)'(cnt_w) + 1 != chk_len)) |=> busy_w);
endmodule

bind refclk_loss_det refclk_loss_det_chk #(
  .DATA_W    (DATA_W),
  .MUL_W     (MUL_W),
  .WIN_SCALE (WIN_SCALE),
  .CNT_W     (CNT_W),
  .PROG_RST  (PROG_RST)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .sel_w     (sel_w),
  .busy_w    (busy_w),
  .cnt_w     (cnt_w),
  .prog_w    (prog_w)
);

// File: tb/tb_refclk_loss_det.sv
`timescale 1ns/1ps
module tb_refclk_loss_det;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;

  int checks = 0;
  int failures = 0;
  int ref_half = 0;
  bit finished = 1'b0;

  // vector: [15:12] multiplier field, [11:4] reference half period (0 = stopped), [0] expected status
  localparam logic [15:0] VEC [8] = '{
    {4'd0,  8'd0,  4'd1},
    {4'd0,  8'd1,  4'd0},
    {4'd1,  8'd0,  4'd1},
    {4'd6,  8'd0,  4'd1},
    {4'd6,  8'd5,  4'd0},
    {4'd15, 8'd0,  4'd1},
    {4'd15, 8'd20, 4'd0},
    {4'd3,  8'd2,  4'd0}
  };

  refclk_loss_det dut (
    .clk       (clk),
    .rst       (rst),
    .ref_clk_i (ref_clk_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o)
  );

  initial forever #2.5 clk = ~clk;

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (ref_half == 0) cnt = 0;
      else begin
        cnt++;
        if (cnt >= ref_half) begin
          cnt = 0;
          ref_clk_i = ~ref_clk_i;
        end
      end
    end
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_ref(int half);
    ref_half = half;
    tick(6);
  endtask

  initial begin
    tick(4);
    @(negedge clk); rst = 1'b0;
    tick(1);
    check("R1 ctrl reset", rd_data_o, 8'h00);
    @(negedge clk); addr_i = 1'b1;
    tick(1);
    check("R1 prog reset", rd_data_o, 8'h66);

    wr(1'b0, 8'h02);
    tick(1);
    check("R1 select readback", rd_data_o, 8'h02);

    set_ref(0);
    wr(1'b0, 8'h01);
    tick(40);
    check("R6 arm without select", rd_data_o, 8'h00);

    for (int i = 0; i < 8; i++) begin
      int n;
      n = (VEC[i][15:12] == 0) ? 1 : int'(VEC[i][15:12]);
      set_ref(int'(VEC[i][11:4]));
      wr(1'b1, {VEC[i][15:12], 4'h6});
      wr(1'b0, 8'h03);
      tick(4 * n + 3);
      check($sformatf("R2 R3 R4 R5 vector %0d", i), {7'd0, rd_data_o[0]}, {7'd0, VEC[i][0]});
    end

    // R9: spare nibble stored, window stays 4 cycles; status 0 from last vector
    wr(1'b1, 8'h1F);
    @(negedge clk); addr_i = 1'b1;
    tick(1);
    check("R9 spare nibble readback", rd_data_o, 8'h1F);
    set_ref(0);
    wr(1'b0, 8'h03);
    tick(4);
    check("R10 status held until window end", {7'd0, rd_data_o[0]}, 8'h00);
    tick(1);
    check("R9 R4 window of 4 cycles", {7'd0, rd_data_o[0]}, 8'h01);

    set_ref(1);
    wr(1'b0, 8'h03);
    tick(10);
    check("R5 active reference clears status", rd_data_o, 8'h02);

    // R7: re-arm two cycles in restarts the window
    set_ref(0);
    wr(1'b0, 8'h03);
    tick(1);
    wr(1'b0, 8'h03);
    tick(3);
    check("R7 restarted window not yet done", {7'd0, rd_data_o[0]}, 8'h00);
    tick(2);
    check("R7 restarted window result", {7'd0, rd_data_o[0]}, 8'h01);

    // R8: zero write mid-check at N=6
    wr(1'b1, 8'h60);
    set_ref(1);
    wr(1'b0, 8'h03);
    tick(30);
    check("R8 setup active", {7'd0, rd_data_o[0]}, 8'h00);
    set_ref(0);
    wr(1'b0, 8'h03);
    tick(3);
    wr(1'b0, 8'h02);
    tick(20);
    check("R8 check continues", {7'd0, rd_data_o[0]}, 8'h00);
    tick(1);
    check("R8 result after zero write", {7'd0, rd_data_o[0]}, 8'h01);

    // R6: deselect aborts and clears
    wr(1'b0, 8'h03);
    tick(3);
    wr(1'b0, 8'h00);
    tick(1);
    check("R6 deselected reads zero", rd_data_o, 8'h00);
    wr(1'b0, 8'h02);
    tick(40);
    check("R6 aborted check leaves status clear", rd_data_o, 8'h02);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule